// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block decides when the CPU of a small 8-bit controller is diverted into an interrupt handler and to which address. It watches five request sources, in fixed index order: external request 0 (index 0), timer 0 overflow (index 1), external request 1 (index 2), timer 1 overflow (index 3) and the serial port (index 4, raised by either its transmit-done or its receive-done flag). A request is taken when the master enable and the source's own enable are both set and its priority outranks the level currently in service. When it takes one, it emits a one-cycle accept pulse, the handler's 16-bit vector, a clear strobe for a timer flag where the source uses one, and a wake strobe that drops the CPU's idle bit.

The two external request flags live inside the block. Each active-low pin is sampled every clock and captured either on a falling edge or as a plain level, chosen per pin. The controller also records which of the two priority levels are in service, so that a high-priority handler can nest inside a low-priority one. The CPU signals the end of a handler with a one-cycle return strobe.

Top module: `irq_ctrl`

## Requirements
- R1: The vector for the source with index k is 0x0003 + 8*k: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023. It is valid in the cycle in which `acceptPulse` is high.
- R2: No request is accepted while `globalEn` is 0. A source whose bit in `srcEn` (bit k for index k) is 0 is never accepted.
- R3: Accepting an external source clears its `extFlag` bit, and accepting a timer source raises `tmrClear` bit i for that timer during the accept cycle. Accepting the serial source clears nothing, so a serial flag that is still set is taken again once its level is retired.
- R4: Bit k of `srcPrio` set makes source k high priority. A high request preempts a low handler. Nothing is accepted while a high handler is active, and a low request waits while any handler is active.
- R5: Among requests of the same priority present in the same cycle, the lowest index wins.
- R6: With `extEdgeSel[i]`=1, a high-to-low change of `extPinN[i]` between two clock samples sets `extFlag[i]`. A pin held low does not set it again after it has been cleared.
- R7: With `extEdgeSel[i]`=0, `extFlag[i]` equals the inverse of the pin sampled in the previous cycle. An accept does not hold it low while the pin stays low.
- R8: `retStrobe` retires the highest active level in the same clock. No request is accepted in the cycle in which the strobe is high. A request that becomes eligible is accepted in the following cycle.
- R9: `idleWake` pulses in exactly the cycles in which `acceptPulse` is high.
- R10: `activeLevel` bit 1 shows a high-priority handler in service and bit 0 a low-priority one. Each bit is set by an accept at that level.
- R11: After reset there is no accept, `activeLevel` is 0 and `extFlag` is 0.
- R12: A request is accepted one clock after its flag is visible to the block: a timer or serial flag driven before a clock edge produces `acceptPulse` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extPinN | input | 2 | External request pins, active low |
| extEdgeSel | input | 2 | Per pin: 1 = falling-edge capture, 0 = level capture |
| tmrFlag | input | 2 | Timer overflow flags |
| serTxDone | input | 1 | Serial transmit-done flag |
| serRxDone | input | 1 | Serial receive-done flag |
| globalEn | input | 1 | Master interrupt enable |
| srcEn | input | 5 | Per-source enable, bit k for source index k |
| srcPrio | input | 5 | Per-source priority, 1 = high |
| retStrobe | input | 1 | Handler return, one cycle |
| acceptPulse | output | 1 | One-cycle accept indication |
| vectorAddr | output | 16 | Handler address of the accepted source |
| tmrClear | output | 2 | Clear strobe for the accepted timer's flag |
| idleWake | output | 1 | Clears the CPU idle bit |
| extFlag | output | 2 | Captured external request flags |
| activeLevel | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
Two collisions are provoked on purpose. In the first, a handler return falls in the cycle where a waiting request would become eligible. The bench samples the ports right after that return edge: it expects no accept and an empty level record there, and the accept one clock later. In the second, a level-mode pin is held low while its request is accepted, so the flag clear and the level sample meet in the same clock. The bench expects the flag to read as still set after the accept. A scoreboard carries the vector and clear strobe of every accept in order, so an early, late or extra accept shows up as a mismatch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_EXT = 2;
  localparam int NUM_TMR = 2;
  localparam int NUM_SRC = NUM_EXT + NUM_TMR + 1;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int SER_IDX = NUM_SRC - 1;

  // index of external source i and timer i in the service order
  function automatic int extIdx(input int i);
    return 2 * i;
  endfunction

  function automatic int tmrIdx(input int i);
    return 2 * i + 1;
  endfunction

  typedef struct packed {
    logic               fire;
    logic [IDX_W-1:0]   idx;
    logic [NUM_EXT-1:0] extClr;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] extPinN,
  input  logic [NUM_EXT-1:0] extEdgeSel,
  input  ctlStrobe_t         strobe,
  output logic [NUM_EXT-1:0] extFlag,
  output logic [VEC_W-1:0]   vectorAddr
);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    logic prevQ;
    logic flagQ;
    logic fallSeen;

    assign fallSeen = prevQ & ~extPinN[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prevQ <= 1'b1;
        flagQ <= 1'b0;
      end else begin
        prevQ <= extPinN[i];
        if (extEdgeSel[i]) begin
          // a fresh edge outranks the clear from an accept
          if (fallSeen)               flagQ <= 1'b1;
          else if (strobe.extClr[i])  flagQ <= 1'b0;
        end else begin
          flagQ <= ~extPinN[i];
        end
      end
    end

    assign extFlag[i] = flagQ;

    // R6: in edge mode the flag only rises after a sampled high-to-low change
    p_edge_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flagQ && !$past(flagQ) && $past(extEdgeSel[i]) && $past(rst_n))
        |-> ($past(prevQ) && !$past(extPinN[i])));

    // R7: in level mode the flag mirrors the inverted pin one sample late
    p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(extEdgeSel[i]) && $past(rst_n)) |-> (flagQ == !$past(extPinN[i])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vectorAddr <= '0;
    end else if (strobe.fire) begin
      vectorAddr <= VEC_W'(VEC_BASE + int'(strobe.idx) * VEC_STEP);
    end
  end

  // R1: a loaded vector always lands on the 8-byte grid above the base
  p_vec_grid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobe.fire) |->
      ((int'(vectorAddr) - VEC_BASE) % VEC_STEP == 0 &&
       int'(vectorAddr) <= VEC_BASE + (NUM_SRC - 1) * VEC_STEP));

endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] extFlag,
  input  logic [NUM_TMR-1:0] tmrFlag,
  input  logic               serTxDone,
  input  logic               serRxDone,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcPrio,
  input  logic               retStrobe,
  output ctlStrobe_t         strobe,
  output logic               acceptPulse,
  output logic [NUM_TMR-1:0] tmrClear,
  output logic               idleWake,
  output logic [1:0]         activeLevel
);

  logic [NUM_SRC-1:0] reqVec;
  logic [NUM_SRC-1:0] eligVec;
  logic [NUM_SRC-1:0] hiVec;
  logic [NUM_SRC-1:0] loVec;
  logic               takeHi;
  logic               takeLo;
  logic               fire;
  logic [IDX_W-1:0]   winIdx;
  logic [1:0]         levelNext;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_reqExt
    assign reqVec[extIdx(i)] = extFlag[i];
  end
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_reqTmr
    assign reqVec[tmrIdx(i)] = tmrFlag[i];
  end
  assign reqVec[SER_IDX] = serTxDone | serRxDone;

  assign eligVec = reqVec & srcEn & {NUM_SRC{globalEn}};
  assign hiVec   = eligVec & srcPrio;
  assign loVec   = eligVec & ~srcPrio;

  function automatic logic [IDX_W-1:0] lowestSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (v[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  // high beats anything but an active high; low needs an idle record
  assign takeHi = (|hiVec) && !activeLevel[1];
  assign takeLo = (|loVec) && (activeLevel == 2'b00);
  assign fire   = (takeHi || takeLo) && !retStrobe;
  assign winIdx = takeHi ? lowestSet(hiVec) : lowestSet(loVec);

  always_comb begin
    strobe.fire = fire;
    strobe.idx  = winIdx;
    for (int i = 0; i < NUM_EXT; i++) begin
      strobe.extClr[i] = fire && (int'(winIdx) == extIdx(i));
    end
  end

  always_comb begin
    levelNext = activeLevel;
    if (retStrobe) begin
      if (activeLevel[1]) levelNext[1] = 1'b0;
      else                levelNext[0] = 1'b0;
    end else if (fire) begin
      if (takeHi) levelNext[1] = 1'b1;
      else        levelNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acceptPulse <= 1'b0;
      idleWake    <= 1'b0;
      tmrClear    <= '0;
      activeLevel <= 2'b00;
    end else begin
      acceptPulse <= fire;
      idleWake    <= fire;
      activeLevel <= levelNext;
      for (int i = 0; i < NUM_TMR; i++) begin
        tmrClear[i] <= fire && (int'(winIdx) == tmrIdx(i));
      end
    end
  end

  // R2: an accept always follows a cycle with the master enable on
  p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acceptPulse |-> $past(globalEn));

  // R4: a running high handler is never interrupted
  p_no_nest_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acceptPulse |-> !$past(activeLevel[1]));

  // R8: the return cycle takes nothing
  p_ret_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retStrobe) |-> !acceptPulse);

  // R3: a timer clear only comes with an accept, and for one timer
  p_tmr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmrClear) |-> (acceptPulse && $onehot0(tmrClear)));

  // R10: a level bit only rises through an accept
  p_level_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(activeLevel[1]) || $rose(activeLevel[0])) |-> acceptPulse);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] extPinN,
  input  logic [NUM_EXT-1:0] extEdgeSel,
  input  logic [NUM_TMR-1:0] tmrFlag,
  input  logic               serTxDone,
  input  logic               serRxDone,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [NUM_SRC-1:0] srcPrio,
  input  logic               retStrobe,
  output logic               acceptPulse,
  output logic [VEC_W-1:0]   vectorAddr,
  output logic [NUM_TMR-1:0] tmrClear,
  output logic               idleWake,
  output logic [NUM_EXT-1:0] extFlag,
  output logic [1:0]         activeLevel
);

  ctlStrobe_t strobe;

  irq_datapath #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .extPinN    (extPinN),
    .extEdgeSel (extEdgeSel),
    .strobe     (strobe),
    .extFlag    (extFlag),
    .vectorAddr (vectorAddr)
  );

  irq_control u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .extFlag     (extFlag),
    .tmrFlag     (tmrFlag),
    .serTxDone   (serTxDone),
    .serRxDone   (serRxDone),
    .globalEn    (globalEn),
    .srcEn       (srcEn),
    .srcPrio     (srcPrio),
    .retStrobe   (retStrobe),
    .strobe      (strobe),
    .acceptPulse (acceptPulse),
    .tmrClear    (tmrClear),
    .idleWake    (idleWake),
    .activeLevel (activeLevel)
  );

  // R9: the wake strobe and the accept are the same event
  p_wake_with_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idleWake == acceptPulse);

endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  extPinN = 2'b11;
  logic [1:0]  extEdgeSel = 2'b11;
  logic [1:0]  tmrFlag = 2'b00;
  logic        serTxDone = 1'b0;
  logic        serRxDone = 1'b0;
  logic        globalEn = 1'b1;
  logic [4:0]  srcEn = 5'b11111;
  logic [4:0]  srcPrio = 5'b00000;
  logic        retStrobe = 1'b0;
  logic        acceptPulse;
  logic [15:0] vectorAddr;
  logic [1:0]  tmrClear;
  logic        idleWake;
  logic [1:0]  extFlag;
  logic [1:0]  activeLevel;

  int testsRun = 0;
  int testsFailed = 0;
  int acceptCount = 0;
  bit finished = 0;
  logic [17:0] expQ[$];   // {vector, timer clear}

  always #2 clk = ~clk;   // 250 MHz

  irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .extPinN(extPinN), .extEdgeSel(extEdgeSel),
    .tmrFlag(tmrFlag), .serTxDone(serTxDone), .serRxDone(serRxDone),
    .globalEn(globalEn), .srcEn(srcEn), .srcPrio(srcPrio),
    .retStrobe(retStrobe), .acceptPulse(acceptPulse), .vectorAddr(vectorAddr),
    .tmrClear(tmrClear), .idleWake(idleWake), .extFlag(extFlag),
    .activeLevel(activeLevel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic expectAcc(input int vec, input int clr);
    expQ.push_back({16'(vec), 2'(clr)});
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReturn();
    @(negedge clk) retStrobe = 1'b1;
    @(negedge clk) retStrobe = 1'b0;
  endtask

  // monitor: scoreboard pop and timer-flag handshake
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && acceptPulse) begin
        acceptCount++;
        chk(idleWake == 1'b1, "R9 wake with accept", idleWake, 1);
        if (expQ.size() == 0) begin
          chk(1'b0, "R2/R4 unexpected accept", vectorAddr, 0);
        end else begin
          logic [17:0] e;
          e = expQ.pop_front();
          chk(vectorAddr == e[17:2], "R1 vector", vectorAddr, e[17:2]);
          chk(tmrClear == e[1:0], "R3 timer clear", tmrClear, e[1:0]);
        end
        for (int i = 0; i < 2; i++) if (tmrClear[i]) tmrFlag[i] = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int snap;
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    // R11 reset state
    chk(acceptPulse == 0 && activeLevel == 0 && extFlag == 0, "R11 reset state",
        {acceptPulse, activeLevel, extFlag}, 0);

    // R12 latency and R1/R10: timer 0 low priority
    expectAcc(16'h000B, 2'b01);
    tmrFlag[0] = 1'b1;
    waitCyc(1);
    chk(acceptPulse == 1, "R12 accept one clock later", acceptPulse, 1);
    waitCyc(3);
    chk(activeLevel == 2'b01, "R10 low level set", activeLevel, 1);
    doReturn();
    waitCyc(1);
    chk(activeLevel == 2'b00, "R8 level retired", activeLevel, 0);

    // R5 fixed order, R3 serial not cleared
    expectAcc(16'h000B, 2'b01);
    expectAcc(16'h001B, 2'b10);
    expectAcc(16'h0023, 2'b00);
    expectAcc(16'h0023, 2'b00);
    tmrFlag = 2'b11;
    serRxDone = 1'b1;
    waitCyc(4);
    doReturn(); waitCyc(4);
    doReturn(); waitCyc(4);
    doReturn(); waitCyc(4);          // serial taken again: flag still set (R3)
    serRxDone = 1'b0;
    doReturn(); waitCyc(4);
    chk(expQ.size() == 0 && activeLevel == 0, "R5 order drained", expQ.size(), 0);

    // R2 master and per-source enables
    snap = acceptCount;
    globalEn = 1'b0;
    tmrFlag[1] = 1'b1;
    waitCyc(5);
    chk(acceptCount == snap, "R2 master enable off", acceptCount, snap);
    srcEn[3] = 1'b0;
    globalEn = 1'b1;
    waitCyc(5);
    chk(acceptCount == snap, "R2 source enable off", acceptCount, snap);
    expectAcc(16'h001B, 2'b10);
    srcEn[3] = 1'b1;
    waitCyc(4);
    chk(acceptCount == snap + 1, "R2 enable restored", acceptCount, snap + 1);
    doReturn(); waitCyc(2);

    // R4 preemption and nesting
    srcPrio = 5'b01001;
    expectAcc(16'h000B, 2'b01);
    tmrFlag[0] = 1'b1;
    waitCyc(4);
    expectAcc(16'h001B, 2'b10);
    tmrFlag[1] = 1'b1;
    waitCyc(4);
    chk(activeLevel == 2'b11, "R4 high preempts low", activeLevel, 3);
    snap = acceptCount;
    extPinN[0] = 1'b0;
    waitCyc(4);
    chk(acceptCount == snap && extFlag[0] == 1, "R4 high blocks high",
        {acceptCount[7:0], extFlag}, {snap[7:0], 2'b01});
    expectAcc(16'h0003, 2'b00);
    doReturn(); waitCyc(4);
    chk(activeLevel == 2'b11, "R4 pending high taken after return", activeLevel, 3);
    chk(extFlag[0] == 0, "R3 external flag cleared", extFlag[0], 0);
    extPinN[0] = 1'b1;
    doReturn(); waitCyc(2);
    chk(activeLevel == 2'b01, "R10 high retired first", activeLevel, 1);
    doReturn(); waitCyc(2);
    srcPrio = 5'b00000;

    // R6 edge mode, pin held low
    expectAcc(16'h0003, 2'b00);
    extPinN[0] = 1'b0;
    waitCyc(4);
    chk(extFlag[0] == 0, "R6 held low no re-set", extFlag[0], 0);
    snap = acceptCount;
    doReturn(); waitCyc(4);
    chk(acceptCount == snap, "R6 no second accept", acceptCount, snap);
    extPinN[0] = 1'b1;
    waitCyc(2);
    expectAcc(16'h0003, 2'b00);
    extPinN[0] = 1'b0;
    waitCyc(4);
    extPinN[0] = 1'b1;
    doReturn(); waitCyc(2);

    // R7 level mode: clear overridden while pin low
    extEdgeSel[1] = 1'b0;
    waitCyc(2);
    expectAcc(16'h0013, 2'b00);
    extPinN[1] = 1'b0;
    waitCyc(4);
    chk(extFlag[1] == 1, "R7 level flag survives accept", extFlag[1], 1);
    extPinN[1] = 1'b1;
    waitCyc(2);
    chk(extFlag[1] == 0, "R7 level flag follows pin", extFlag[1], 0);
    doReturn(); waitCyc(2);

    // R8 return and waiting request in the same cycle
    expectAcc(16'h000B, 2'b01);
    tmrFlag[0] = 1'b1;
    waitCyc(4);
    tmrFlag[1] = 1'b1;
    waitCyc(3);
    expectAcc(16'h001B, 2'b10);
    doReturn();
    chk(acceptPulse == 0 && activeLevel == 0, "R8 no accept in return cycle",
        {acceptPulse, activeLevel}, 0);
    waitCyc(1);
    chk(acceptPulse == 1, "R8 accept next cycle", acceptPulse, 1);
    doReturn(); waitCyc(3);

    chk(expQ.size() == 0, "R1 scoreboard empty", expQ.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule